// File: doc/BRIEF.md
# SPI Boot Stream Reader

This block is the serial-flash side of a boot path. After reset, a one-cycle start pulse with a nonzero word count makes it act as an SPI master. It lowers chip select and clocks out a fixed 32-bit read command: an 8-bit read opcode followed by a 24-bit zero address, sent least significant bit first. Because the link is full duplex, 32 bits arrive on MISO while the command goes out. The block drops them in hardware.

After the command it keeps clocking with MOSI held low. It assembles each 32 received bits, least significant bit first, into a word and offers that word on a valid/ready stream. When the programmed number of words has been handed to the output register, it releases chip select and pulses done. An abort input stops the transfer at any point.

The serial clock is the system clock divided by an even parameter, in mode 0 (idle low). If the consumer is slow, the serial clock stops at a word boundary, so no bit is lost.

Top module: `boot_spi_reader`

## Requirements
- R1: Out of reset and whenever idle, `cs_n_o` is high, `sclk_o` is low, `mosi_o` is low, and `busy_o`, `valid_o` and `done_o` are low.
- R2: A start accepted while idle lowers `cs_n_o` in the next cycle. The first rising edge of `sclk_o` follows CLK_DIV/2 cycles after chip select goes low.
- R3: The first 32 bits on `mosi_o` form the command. Collected least significant bit first, they equal 32'h000000C0: opcode 0xC0 in bits 7:0 and a zero address in bits 31:8. In wire order, the first eight bits read MSB-first give 0x03. `mosi_o` stays low for every later bit of the transfer.
- R4: SCLK uses mode 0. Each half-period lasts CLK_DIV/2 system cycles. `mosi_o` changes only when `sclk_o` falls or when `cs_n_o` changes. `miso_i` is sampled when `sclk_o` rises.
- R5: The 32 bits received during the command never appear on `data_o` as a delivered word.
- R6: Each delivered word holds 32 received data bits. The first bit received after the command is bit 0.
- R7: A word stays on `data_o` with `valid_o` high until `ready_i` accepts it. While a word is held, `sclk_o` does not begin the next word. No data bit is lost or repeated.
- R8: `done_o` pulses for one cycle in the cycle the last word becomes valid. In that same cycle `cs_n_o` returns high and `busy_o` falls.
- R9: `abort_i` while busy makes `cs_n_o` high, `sclk_o` low and `busy_o` low in the next cycle. No done pulse is given and the partly received word is dropped. A later start runs normally.
- R10: A start with a word count of zero is ignored. A start while busy is ignored and does not change the running word count.
- R11: `cs_n_o` stays low continuously from the accepted start until the last word or an abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to begin a boot read |
| abort_i | input | 1 | Stop the current transfer at once |
| word_count_i | input | CNT_W | Number of 32-bit data words to fetch, sampled at start |
| sclk_o | output | 1 | Serial clock, idle low |
| cs_n_o | output | 1 | Active-low chip select |
| mosi_o | output | 1 | Serial data toward the memory |
| miso_i | input | 1 | Serial data from the memory |
| data_o | output | WORD_W | Received word |
| valid_o | output | 1 | `data_o` holds an undelivered word |
| ready_i | input | 1 | Consumer accepts the word on `data_o` |
| busy_o | output | 1 | Transfer in progress (chip select low) |
| done_o | output | 1 | One-cycle pulse when the last word is loaded |

## Verification
The hardest case to reach is the back-pressure stall. The serial clock must freeze exactly at a word boundary and then restart without dropping or repeating a bit. The bench holds `ready_i` low for hundreds of cycles after the first word appears, then replays a toggling ready pattern. A slave model shifts a known image out on MISO, and every word is compared in order.

The bench also aborts in two places: inside the 32-bit command, and halfway through a data word. This shows that discarded bits never reach the output and that a later run recovers cleanly.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOW  = 2'd1,
      ST_HIGH = 2'd2
   } seq_state_t;

   typedef enum logic {
      PH_CMD  = 1'b0,
      PH_DATA = 1'b1
   } phase_t;
endpackage

// File: rtl/bsr_clkdiv.sv
module bsr_clkdiv #(
   parameter int HALF = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic hold,
   output logic tick
);
   localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
   localparam logic [CW-1:0] LAST = CW'(HALF - 1);

   generate
      if (HALF < 1) begin : g_bad_half
         $error("bsr_clkdiv: HALF must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   generate
      if (HALF == 1) begin : g_fast
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt_q <= '0;
            else        cnt_q <= '0;
         end
         assign tick = run && (cnt_q == LAST);
      end else begin : g_count
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (!run) begin
               cnt_q <= '0;
            end else if (cnt_q == LAST) begin
               if (!hold) cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
         assign tick = run && (cnt_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/bsr_shift.sv
module bsr_shift #(
   parameter int          CMD_W    = 32,
   parameter int          WORD_W   = 32,
   parameter logic [31:0] CMD_WORD = 32'h0000_00C0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              clear,
   input  logic              fall_adv,
   input  logic              rise_adv,
   input  logic              miso,
   output logic              mosi,
   output logic [WORD_W-1:0] rx_word
);
   generate
      if (CMD_W > 32 || CMD_W < 2) begin : g_bad_cmd
         $error("bsr_shift: CMD_W must lie in 2..32");
      end
      if (WORD_W < 2) begin : g_bad_word
         $error("bsr_shift: WORD_W must be at least 2");
      end
   endgenerate

   localparam logic [CMD_W-1:0] CMD_INIT = CMD_WORD[CMD_W-1:0];

   logic [CMD_W-1:0]  tx_q;
   logic [WORD_W-1:0] rx_q;

   // transmit: bit 0 is on the wire; the shift happens on each falling edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        tx_q <= '0;
      else if (clear)    tx_q <= '0;
      else if (load)     tx_q <= CMD_INIT;
      else if (fall_adv) tx_q <= {1'b0, tx_q[CMD_W-1:1]};
   end

   // receive: the newest bit enters at the top, so the first bit ends at bit 0
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        rx_q <= '0;
      else if (rise_adv) rx_q <= {miso, rx_q[WORD_W-1:1]};
   end

   assign mosi    = tx_q[0];
   assign rx_word = rx_q;

   assert_no_load_clear_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      !(load && clear));
endmodule

// File: rtl/bsr_seq.sv
module bsr_seq
   import bsr_pkg::*;
#(
   parameter int CMD_W  = 32,
   parameter int WORD_W = 32,
   parameter int CNT_W  = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             abort,
   input  logic [CNT_W-1:0] word_count,
   input  logic             tick,
   input  logic             out_full,
   output logic             run,
   output logic             hold,
   output logic             load,
   output logic             clear,
   output logic             rise_adv,
   output logic             fall_adv,
   output logic             push,
   output logic             data_phase,
   output logic             sclk,
   output logic             cs_n,
   output logic             busy,
   output logic             done
);
   localparam int MAXW = (CMD_W > WORD_W) ? CMD_W : WORD_W;
   localparam int BW   = $clog2(MAXW);
   localparam logic [BW-1:0] CMD_LAST  = BW'(CMD_W - 1);
   localparam logic [BW-1:0] DATA_LAST = BW'(WORD_W - 1);

   generate
      if (CNT_W < 1) begin : g_bad_cnt
         $error("bsr_seq: CNT_W must be at least 1");
      end
   endgenerate

   seq_state_t       state_q;
   phase_t           phase_q;
   logic [BW-1:0]    bit_q;
   logic [CNT_W-1:0] left_q;
   logic             sclk_q, cs_n_q, done_q;

   logic accept, kill, adv, frame_end, last_word, finish;

   assign busy      = (state_q != ST_IDLE);
   assign accept    = !busy && start && (word_count != '0);
   assign kill      = busy && abort;
   assign hold      = (state_q == ST_LOW) && (phase_q == PH_DATA) &&
                      (bit_q == '0) && out_full;
   assign run       = busy;
   assign adv       = tick && !hold && !abort;
   assign rise_adv  = (state_q == ST_LOW)  && adv;
   assign fall_adv  = (state_q == ST_HIGH) && adv;
   assign frame_end = fall_adv &&
                      (bit_q == ((phase_q == PH_CMD) ? CMD_LAST : DATA_LAST));
   assign last_word = (left_q == CNT_W'(1));
   assign push      = frame_end && (phase_q == PH_DATA);
   assign finish    = push && last_word;
   assign load      = accept;
   assign clear     = kill || finish;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         phase_q <= PH_CMD;
         bit_q   <= '0;
         left_q  <= '0;
      end else if (kill) begin
         state_q <= ST_IDLE;
         phase_q <= PH_CMD;
         bit_q   <= '0;
      end else begin
         case (state_q)
            ST_IDLE: if (accept) begin
               state_q <= ST_LOW;
               phase_q <= PH_CMD;
               bit_q   <= '0;
               left_q  <= word_count;
            end
            ST_LOW: if (rise_adv) state_q <= ST_HIGH;
            ST_HIGH: if (fall_adv) begin
               if (frame_end) begin
                  bit_q <= '0;
                  if (phase_q == PH_CMD) begin
                     phase_q <= PH_DATA;
                     state_q <= ST_LOW;
                  end else begin
                     left_q <= left_q - 1'b1;
                     if (last_word) begin
                        state_q <= ST_IDLE;
                        phase_q <= PH_CMD;
                     end else begin
                        state_q <= ST_LOW;
                     end
                  end
               end else begin
                  bit_q   <= bit_q + 1'b1;
                  state_q <= ST_LOW;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q <= 1'b0;
         cs_n_q <= 1'b1;
         done_q <= 1'b0;
      end else begin
         done_q <= finish;
         if (accept)             cs_n_q <= 1'b0;
         else if (clear)         cs_n_q <= 1'b1;
         if (kill || fall_adv)   sclk_q <= 1'b0;
         else if (rise_adv)      sclk_q <= 1'b1;
      end
   end

   assign sclk       = sclk_q;
   assign cs_n       = cs_n_q;
   assign done       = done_q;
   assign data_phase = busy && (phase_q == PH_DATA);

   assert_idle_lines_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (cs_n_q && !sclk_q));
   assert_cs_held_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !cs_n_q);
   assert_done_release_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (cs_n_q && !busy));
   assert_abort_stop_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (busy && abort) |=> (!busy && cs_n_q && !sclk_q && !done_q));
   assert_zero_count_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start && (word_count == '0)) |=> !busy);
endmodule

// File: rtl/bsr_outreg.sv
module bsr_outreg #(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [WORD_W-1:0] din,
   input  logic              ready,
   output logic              valid,
   output logic [WORD_W-1:0] dout
);
   logic              valid_q;
   logic [WORD_W-1:0] data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         data_q  <= '0;
      end else if (push) begin
         valid_q <= 1'b1;
         data_q  <= din;
      end else if (valid_q && ready) begin
         valid_q <= 1'b0;
      end
   end

   assign valid = valid_q;
   assign dout  = data_q;

   assert_no_overflow_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !valid_q);
   assert_hold_word_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q && !ready) |=> (valid_q && $stable(data_q)));
endmodule

// File: rtl/boot_spi_reader.sv
module boot_spi_reader #(
   parameter int         CLK_DIV  = 4,
   parameter int         WORD_W   = 32,
   parameter int         CNT_W    = 16,
   parameter int         ADDR_W   = 24,
   parameter logic [7:0] READ_OPC = 8'hC0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              abort_i,
   input  logic [CNT_W-1:0]  word_count_i,
   output logic              sclk_o,
   output logic              cs_n_o,
   output logic              mosi_o,
   input  logic              miso_i,
   output logic [WORD_W-1:0] data_o,
   output logic              valid_o,
   input  logic              ready_i,
   output logic              busy_o,
   output logic              done_o
);
   localparam int          HALF     = CLK_DIV / 2;
   localparam int          CMD_W    = 8 + ADDR_W;
   localparam logic [31:0] CMD_WORD = {{(32 - 8){1'b0}}, READ_OPC};

   generate
      if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
         $error("boot_spi_reader: CLK_DIV must be even and at least 2");
      end
      if (ADDR_W > 24 || ADDR_W < 1) begin : g_bad_addr
         $error("boot_spi_reader: ADDR_W must lie in 1..24");
      end
   endgenerate

   logic run, hold, tick, load, clear, rise_adv, fall_adv, push, data_phase;
   logic [WORD_W-1:0] rx_word;

   bsr_clkdiv #(.HALF(HALF)) u_div (
      .clk (clk), .rst_n (rst_n), .run (run), .hold (hold), .tick (tick)
   );

   bsr_seq #(.CMD_W(CMD_W), .WORD_W(WORD_W), .CNT_W(CNT_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start_i),
      .abort      (abort_i),
      .word_count (word_count_i),
      .tick       (tick),
      .out_full   (valid_o),
      .run        (run),
      .hold       (hold),
      .load       (load),
      .clear      (clear),
      .rise_adv   (rise_adv),
      .fall_adv   (fall_adv),
      .push       (push),
      .data_phase (data_phase),
      .sclk       (sclk_o),
      .cs_n       (cs_n_o),
      .busy       (busy_o),
      .done       (done_o)
   );

   bsr_shift #(.CMD_W(CMD_W), .WORD_W(WORD_W), .CMD_WORD(CMD_WORD)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .clear    (clear),
      .fall_adv (fall_adv),
      .rise_adv (rise_adv),
      .miso     (miso_i),
      .mosi     (mosi_o),
      .rx_word  (rx_word)
   );

   bsr_outreg #(.WORD_W(WORD_W)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push),
      .din   (rx_word),
      .ready (ready_i),
      .valid (valid_o),
      .dout  (data_o)
   );

   assert_sclk_stall_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sclk_o) |-> !$past(valid_o));
   assert_mosi_data_low_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      data_phase |-> !mosi_o);
   assert_mosi_edges_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mosi_o) |-> ($fell(sclk_o) || $fell(cs_n_o) || $rose(cs_n_o)));
   assert_done_valid_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> valid_o);
endmodule

// File: tb/boot_spi_reader_tb.sv
module boot_spi_reader_tb;
   localparam int          CNT_W = 16;
   localparam logic [31:0] JUNK  = 32'hDEAD_BEEF;

   logic clk = 1'b0, rst_n = 1'b0;
   logic start_i = 1'b0, abort_i = 1'b0, miso_i = 1'b0, ready_i = 1'b1;
   logic [CNT_W-1:0] word_count_i = '0;
   logic sclk_o, cs_n_o, mosi_o, valid_o, busy_o, done_o;
   logic [31:0] data_o;

   always #4 clk = ~clk;

   boot_spi_reader #(.CLK_DIV(4), .CNT_W(CNT_W)) u_dut (
      .clk (clk), .rst_n (rst_n), .start_i (start_i), .abort_i (abort_i),
      .word_count_i (word_count_i), .sclk_o (sclk_o), .cs_n_o (cs_n_o),
      .mosi_o (mosi_o), .miso_i (miso_i), .data_o (data_o), .valid_o (valid_o),
      .ready_i (ready_i), .busy_o (busy_o), .done_o (done_o)
   );

   int checks = 0, errors = 0, done_cnt = 0, ready_mode = 1, cyc = 0;
   logic [31:0] exp_q[$];
   logic [31:0] img [0:7];
   logic [31:0] cmd_bits;
   int idx = 0, mosi_hi = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string req, input string msg,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, msg, act, exp);
      end
   endtask

   function automatic logic slave_bit(input int k);
      if (k < 32) return JUNK[k];
      if ((k - 32) / 32 < 8) return img[(k - 32) / 32][(k - 32) % 32];
      return 1'b0;
   endfunction

   // slave model, mode 0: drive on falling edge, record MOSI on rising edge
   always @(negedge cs_n_o) begin
      idx = 0; cmd_bits = '0; mosi_hi = 0;
      miso_i = slave_bit(0);
   end
   always @(posedge sclk_o) begin
      if (!cs_n_o) begin
         if (idx < 32) cmd_bits[idx] = mosi_o;
         else if (mosi_o) mosi_hi++;
      end
   end
   always @(negedge sclk_o) begin
      idx++;
      miso_i = slave_bit(idx);
   end

   // ready driver, changes just after the rising edge
   initial forever begin
      @(posedge clk); #1;
      cyc++;
      case (ready_mode)
         0: ready_i = 1'b0;
         2: ready_i = ((cyc % 7) < 3);
         default: ready_i = 1'b1;
      endcase
   end

   // monitor / scoreboard
   logic prev_sclk = 1'b0, prev_valid = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (sclk_o && !prev_sclk)
            chk(!prev_valid, "R7", "sclk rose while word held", {31'd0, prev_valid}, 32'd0);
         if (valid_o && ready_i) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R7", "unexpected extra word", data_o, 32'd0);
            end else begin
               logic [31:0] e;
               e = exp_q.pop_front();
               chk(data_o == e, "R6", "delivered word", data_o, e);
               chk(data_o != JUNK, "R5", "command-phase bits leaked", data_o, e);
            end
         end
         if (done_o) begin
            done_cnt++;
            chk(cs_n_o && !busy_o && valid_o, "R8", "done with cs/busy/valid",
                {29'd0, cs_n_o, busy_o, valid_o}, 32'd5);
         end
      end
      prev_sclk  = sclk_o;
      prev_valid = valid_o;
   end

   task automatic fill_img(input int seed);
      for (int i = 0; i < 8; i++)
         img[i] = (32'h9E37_79B9 * (seed * 8 + i + 1)) ^ 32'h0F0F_3C3C;
   endtask

   task automatic start_run(input int n);
      for (int i = 0; i < n; i++) exp_q.push_back(img[i]);
      @(negedge clk); word_count_i = CNT_W'(n); start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 6000 && busy_o; i++) @(negedge clk);
      repeat (10) @(negedge clk);
   endtask

   task automatic do_abort();
      @(negedge clk); abort_i = 1'b1;
      @(negedge clk); abort_i = 1'b0;
      chk(!busy_o && cs_n_o && !sclk_o, "R9", "lines after abort",
          {29'd0, busy_o, cs_n_o, sclk_o}, 32'd2);
   endtask

   task automatic finish_sim();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      chk(1'b0, "R1", "watchdog expired", 32'd0, 32'd1);
      finish_sim();
   end

   initial begin
      int d0;
      logic [7:0] wire8;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cs_n_o && !sclk_o && !mosi_o && !valid_o && !busy_o && !done_o, "R1",
          "reset state", {26'd0, cs_n_o, sclk_o, mosi_o, valid_o, busy_o, done_o}, 32'h20);

      // R10: zero count ignored
      @(negedge clk); word_count_i = '0; start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
      repeat (10) @(negedge clk);
      chk(!busy_o && cs_n_o, "R10", "zero-count start ignored", {31'd0, busy_o}, 32'd0);

      // run A: 2 words, lead timing, command content, restart ignored
      fill_img(1);
      ready_mode = 1;
      start_run(2);
      chk(!cs_n_o && !sclk_o, "R2", "cs low before first edge", {30'd0, cs_n_o, sclk_o}, 32'd0);
      @(negedge clk);
      chk(!sclk_o, "R2", "sclk still low after one cycle", {31'd0, sclk_o}, 32'd0);
      @(negedge clk);
      chk(sclk_o, "R2", "first rising edge after half period", {31'd0, sclk_o}, 32'd1);
      @(negedge clk);
      chk(sclk_o, "R4", "sclk high for half period", {31'd0, sclk_o}, 32'd1);
      @(negedge clk);
      chk(!sclk_o, "R4", "sclk falls after half period", {31'd0, sclk_o}, 32'd0);
      repeat (20) @(negedge clk);
      word_count_i = CNT_W'(5); start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
      chk(!cs_n_o, "R11", "cs low mid command", {31'd0, cs_n_o}, 32'd0);
      wait_idle();
      chk(cmd_bits == 32'h0000_00C0, "R3", "command word LSB-first", cmd_bits, 32'h0000_00C0);
      for (int i = 0; i < 8; i++) wire8[7 - i] = cmd_bits[i];
      chk(wire8 == 8'h03, "R3", "opcode in wire order MSB-first", {24'd0, wire8}, 32'h03);
      chk(mosi_hi == 0, "R3", "mosi high in data phase", mosi_hi, 32'd0);
      chk(done_cnt == 1, "R10", "restart while busy ignored; one done", done_cnt, 32'd1);
      chk(exp_q.size() == 0, "R6", "all words delivered", exp_q.size(), 32'd0);

      // run B: 4 words, toggling ready
      fill_img(2);
      ready_mode = 2;
      start_run(4);
      wait_idle();
      ready_mode = 1;
      repeat (5) @(negedge clk);
      chk(exp_q.size() == 0, "R7", "toggling ready, no loss", exp_q.size(), 32'd0);
      chk(done_cnt == 2, "R8", "done count after run B", done_cnt, 32'd2);

      // run C: stall with ready low
      fill_img(3);
      ready_mode = 0;
      start_run(3);
      for (int i = 0; i < 2000 && !valid_o; i++) @(negedge clk);
      repeat (3) @(negedge clk);
      begin
         int moves = 0;
         for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (sclk_o || cs_n_o) moves++;
         end
         chk(moves == 0, "R7", "sclk frozen, cs held during stall", moves, 32'd0);
      end
      chk(valid_o && data_o == img[0], "R7", "word held during stall", data_o, img[0]);
      ready_mode = 1;
      wait_idle();
      chk(exp_q.size() == 0, "R7", "stalled run delivered all", exp_q.size(), 32'd0);
      chk(done_cnt == 3, "R8", "done count after run C", done_cnt, 32'd3);

      // abort during command
      fill_img(4);
      start_run(2);
      repeat (40) @(negedge clk);
      do_abort();
      exp_q.delete();
      repeat (200) @(negedge clk);
      chk(!valid_o && done_cnt == 3, "R9", "no word/done after command abort",
          {31'd0, valid_o}, 32'd0);

      // abort mid second word
      fill_img(5);
      start_run(3);
      for (int i = 0; i < 2000 && !valid_o; i++) @(negedge clk);
      repeat (60) @(negedge clk);
      do_abort();
      d0 = done_cnt;
      repeat (5) @(negedge clk);
      exp_q.delete();
      repeat (300) @(negedge clk);
      chk(!valid_o && done_cnt == d0, "R9", "partial word dropped after abort",
          {31'd0, valid_o}, 32'd0);

      // recovery
      fill_img(6);
      start_run(1);
      wait_idle();
      chk(exp_q.size() == 0 && done_cnt == 4, "R9", "run after abort", done_cnt, 32'd4);
      chk(cmd_bits == 32'h0000_00C0, "R3", "command after abort", cmd_bits, 32'h0000_00C0);
      chk(cs_n_o && !busy_o && !sclk_o && !mosi_o, "R1", "idle after final run",
          {28'd0, cs_n_o, busy_o, sclk_o, mosi_o}, 32'h8);
      finish_sim();
   end
endmodule